// File: doc/BRIEF.md
# Quadrature Link Position Tracker

This block follows the angle of a geared link from two encoder channels whose square waves are 90 degrees apart in phase. Both channels are brought into the clock domain through two-flop synchronizers. On every synchronized rising edge of channel A, a direction flop records the level of channel B. That level decides whether the edge becomes an increment or a decrement of a position register.

The position register is unsigned and tracks the link across a half turn, from -90 to +90 degrees around vertical. With the default parameters this span is 0 to 24000 counts, and vertical is 12000. The register stops at either end of that span instead of wrapping. A synchronous preset input returns it to the vertical value. Only the upper eight bits of the register leave the block, to drive an LED bar. The current rotation sense leaves on a separate output.

Top module: `quad_link_tracker`

## Requirements
- R1: While the reset input is low, and after it is released, the position equals POS_VERT (default 12000) and dir_o is 0. With the default width, disp_o therefore reads 93.
- R2: Each channel passes through a two-flop synchronizer. A level change applied to chan_a just after a clock edge reaches dir_o and the position on the third rising clock edge after it, and not before.
- R3: A synchronized rising edge of chan_a while chan_b is low raises the position by exactly one and sets dir_o to 1.
- R4: A synchronized rising edge of chan_a while chan_b is high lowers the position by exactly one and sets dir_o to 0.
- R5: A falling edge of chan_a, or any transition of chan_b alone, leaves both the position and dir_o unchanged.
- R6: The position saturates at POS_MAX (default 24000). Further up-edges keep it at POS_MAX, while dir_o still follows R3.
- R7: The position saturates at 0. Further down-edges keep it at 0, while dir_o still follows R4.
- R8: When preset is high at a clock edge, the position becomes POS_VERT on that edge. This takes priority over a count on the same edge, although dir_o is still updated by that edge.
- R9: disp_o equals the DISP_W most significant bits of the POS_W-bit position. One display step is therefore 2^(POS_W-DISP_W) counts, which is 128 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| chan_a | input | 1 | Encoder channel A, asynchronous |
| chan_b | input | 1 | Encoder channel B, asynchronous |
| preset | input | 1 | Synchronous load of the vertical reference value |
| disp_o | output | DISP_W (8) | Upper bits of the position, for the LED bar |
| dir_o | output | 1 | Rotation sense: 1 when the last A edge counted up, 0 when it counted down |

## Verification
The bench drives full quadrature cycles in both directions on a reduced configuration: a 10-bit position, a top of 600 and a vertical value of 300. Forward runs are long enough to push the position into its upper stop, and reverse runs long enough to reach its lower stop. A design that wraps at either stop shows a display jump from the maximum to zero, or the reverse. A design that counts on both edges of A, or on B transitions, drifts by twice the expected rate or moves during pure B jitter. The bench also checks the exact edge at which dir_o changes, so a missing or extra synchronizer stage is caught as a one-cycle shift. It places a preset on the same edge as a count to catch a design that gives the count priority over the load.

// File: rtl/qe_pkg.sv
package qe_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_LOAD = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/qe_reset_sync.sv
module qe_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/qe_sync.sv
module qe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qe_dir_detect.sv
module qe_dir_detect
  import qe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    a_s,
  input  logic    b_s,
  input  logic    preset,
  output logic    a_rise_o,
  output logic    dir_o,
  output cnt_op_e op_o
);
  logic a_prev_q;
  logic dir_q;
  logic dir_d;
  logic dir_en;

  assign a_rise_o = a_s & ~a_prev_q;

  // Direction: B low when A rises means counting up.
  always_comb begin
    dir_en = a_rise_o;
    dir_d  = ~b_s;
    if (preset)        op_o = CNT_LOAD;
    else if (!a_rise_o) op_o = CNT_HOLD;
    else if (!b_s)     op_o = CNT_INC;
    else               op_o = CNT_DEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_prev_q <= 1'b0;
    else        a_prev_q <= a_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_en) dir_q <= dir_d;
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/qe_pos_counter.sv
module qe_pos_counter
  import qe_pkg::*;
#(
  parameter int POS_W    = 15,
  parameter int POS_MAX  = 24000,
  parameter int POS_VERT = 12000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MAX_V  = POS_W'(POS_MAX);
  localparam logic [POS_W-1:0] VERT_V = POS_W'(POS_VERT);
  localparam logic [POS_W-1:0] ONE_V  = POS_W'(1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic             pos_en;

  always_comb begin
    pos_d  = pos_q;
    pos_en = 1'b0;
    unique case (op_i)
      CNT_LOAD: begin
        pos_d  = VERT_V;
        pos_en = 1'b1;
      end
      CNT_INC: begin
        pos_en = (pos_q != MAX_V);
        pos_d  = pos_q + ONE_V;
      end
      CNT_DEC: begin
        pos_en = (pos_q != '0);
        pos_d  = pos_q - ONE_V;
      end
      default: begin
        pos_d  = pos_q;
        pos_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= VERT_V;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/quad_link_tracker.sv
module quad_link_tracker
  import qe_pkg::*;
#(
  parameter int POS_W       = 15,
  parameter int POS_MAX     = 24000,
  parameter int POS_VERT    = 12000,
  parameter int DISP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_a,
  input  logic              chan_b,
  input  logic              preset,
  output logic [DISP_W-1:0] disp_o,
  output logic              dir_o
);
  localparam int NCHAN = 2;

  logic             rst_sync_n;
  logic [NCHAN-1:0] chan_raw;
  logic [NCHAN-1:0] chan_s;
  logic             a_sync;
  logic             b_sync;
  logic             a_rise;
  cnt_op_e          cnt_op;
  logic [POS_W-1:0] pos_q;

  qe_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign chan_raw = {chan_b, chan_a};

  generate
    for (genvar i = 0; i < NCHAN; i++) begin : g_sync
      qe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .d_i   (chan_raw[i]),
        .q_o   (chan_s[i])
      );
    end
  endgenerate

  assign a_sync = chan_s[0];
  assign b_sync = chan_s[1];

  qe_dir_detect u_dir (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .a_s      (a_sync),
    .b_s      (b_sync),
    .preset   (preset),
    .a_rise_o (a_rise),
    .dir_o    (dir_o),
    .op_o     (cnt_op)
  );

  qe_pos_counter #(
    .POS_W    (POS_W),
    .POS_MAX  (POS_MAX),
    .POS_VERT (POS_VERT)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op_i  (cnt_op),
    .pos_o (pos_q)
  );

  assign disp_o = pos_q[POS_W-1 -: DISP_W];
endmodule

// File: rtl/qe_tracker_checker.sv
module qe_tracker_checker #(
  parameter int POS_W    = 15,
  parameter int POS_MAX  = 24000,
  parameter int POS_VERT = 12000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preset,
  input logic             a_rise,
  input logic             b_s,
  input logic [POS_W-1:0] pos,
  input logic             dir_o
);
  localparam logic [POS_W-1:0] MAX_V  = POS_W'(POS_MAX);
  localparam logic [POS_W-1:0] VERT_V = POS_W'(POS_VERT);
  localparam logic [POS_W-1:0] ONE_V  = POS_W'(1);

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= MAX_V);

  assert_preset_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> pos == VERT_V);

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && !b_s && !preset && pos != MAX_V) |=> pos == $past(pos) + ONE_V);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && b_s && !preset && pos != '0) |=> pos == $past(pos) - ONE_V);

  assert_hold_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_rise && !preset) |=> ($stable(pos) && $stable(dir_o)));

  assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && !b_s && !preset && pos == MAX_V) |=> pos == MAX_V);

  assert_sat_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && b_s && !preset && pos == '0) |=> pos == '0);

  assert_dir_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_rise |=> dir_o == !$past(b_s));
endmodule

bind quad_link_tracker qe_tracker_checker #(
  .POS_W    (POS_W),
  .POS_MAX  (POS_MAX),
  .POS_VERT (POS_VERT)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .preset (preset),
  .a_rise (a_rise),
  .b_s    (b_sync),
  .pos    (pos_q),
  .dir_o  (dir_o)
);

// File: tb/tb_quad_link_tracker.sv
module tb_quad_link_tracker;
  localparam int TPOS_W = 10;
  localparam int TMAX   = 600;
  localparam int TVERT  = 300;
  localparam int TDISP  = 8;
  localparam int SHIFT  = TPOS_W - TDISP;

  logic clk;
  logic rst_n;
  logic chan_a;
  logic chan_b;
  logic preset;
  logic [TDISP-1:0] disp_o;
  logic dir_o;

  int n_vec;
  int n_bad;
  int m_pos;
  bit m_dir;
  bit done;

  quad_link_tracker #(
    .POS_W    (TPOS_W),
    .POS_MAX  (TMAX),
    .POS_VERT (TVERT),
    .DISP_W   (TDISP)
  ) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .chan_a (chan_a),
    .chan_b (chan_b),
    .preset (preset),
    .disp_o (disp_o),
    .dir_o  (dir_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req);
    int exp_disp;
    exp_disp = m_pos >> SHIFT;
    n_vec++;
    if (int'(disp_o) != exp_disp || dir_o != m_dir) begin
      n_bad++;
      $display("FAIL %s: disp=%0d dir=%0d expected disp=%0d dir=%0d",
               req, disp_o, dir_o, exp_disp, m_dir);
    end
  endtask

  // Apply one channel state, allow synchronizer plus count latency, then check.
  task automatic drive(input bit na, input bit nb);
    string tag;
    bit rise;
    rise   = na && !chan_a;
    chan_a = na;
    chan_b = nb;
    repeat (3) @(negedge clk);
    tag = "R5";
    if (rise) begin
      m_dir = !nb;
      if (!nb) begin
        if (m_pos == TMAX) tag = "R6";
        else begin tag = "R3"; m_pos++; end
      end else begin
        if (m_pos == 0) tag = "R7";
        else begin tag = "R4"; m_pos--; end
      end
    end
    check(tag);
  endtask

  task automatic fwd(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0); drive(1'b1, 1'b1); drive(1'b0, 1'b1); drive(1'b0, 1'b0);
    end
  endtask

  task automatic rev(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_pos = TVERT; m_dir = 1'b0;
    rst_n = 1'b0; chan_a = 1'b0; chan_b = 1'b0; preset = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");

    // R2: latency of an A rise with B low, observed on dir_o
    chan_a = 1'b1;
    @(negedge clk);
    check("R2 one edge");
    @(negedge clk);
    check("R2 two edges");
    @(negedge clk);
    m_dir = 1'b1; m_pos++;
    check("R2 three edges");
    drive(1'b1, 1'b1); drive(1'b0, 1'b1); drive(1'b0, 1'b0);

    // R3 then R6: run forward past the upper stop
    fwd(TMAX - TVERT + 20);
    m_pos = TMAX;
    check("R9 full-scale display");

    // R5: B jitter and A falling do nothing
    for (int i = 0; i < 6; i++) drive(1'b0, i[0] ? 1'b0 : 1'b1);
    drive(1'b0, 1'b0);

    // R4 then R7: run backward past the lower stop
    rev(TMAX + 20);
    for (int i = 0; i < 6; i++) drive(1'b0, i[0] ? 1'b0 : 1'b1);
    drive(1'b0, 1'b0);

    // Sweep every value through the low range with a mixed pattern
    for (int k = 0; k < 12; k++) begin
      fwd(3 + k);
      rev(2);
    end

    // R8: preset alone
    @(negedge clk) preset = 1'b1;
    @(negedge clk) preset = 1'b0;
    m_pos = TVERT;
    @(negedge clk);
    check("R8 preset alone");

    // R8: preset on the same edge as a down count
    drive(1'b0, 1'b1);
    chan_a = 1'b1;
    @(negedge clk);
    @(negedge clk) preset = 1'b1;
    @(negedge clk) preset = 1'b0;
    m_pos = TVERT; m_dir = 1'b0;
    check("R8 preset beats count");
    drive(1'b1, 1'b0); drive(1'b0, 1'b0);

    rev(5);
    fwd(9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule